// File: doc/BRIEF.md
# Programmable memory pattern sequencer

This block is a small microcoded engine that plays out memory-cycle patterns. A 64-word pattern RAM holds short routines. Each word carries a control field that drives the external memory strobes, plus two flag bits. The first flag marks the final word of a routine. The second makes the engine wait for transfer acknowledges. A request selects the word where execution starts. The request can be a single-beat or burst read or write, a refresh tick, a software RUN command that names any word, or a bus-monitor timeout. Once started, the engine presents one word per clock until it completes a word flagged as final.

A burst always carries 32 bytes. An acknowledge-sampling word therefore holds until the beat count for the current port width has been acknowledged. That count is 32 beats on an 8-bit port, 16 on a 16-bit port and 8 on a 32-bit port. A single-beat access needs exactly one acknowledge. A timeout preempts any routine other than the exception routine itself and diverts execution there. When a routine ends, the engine gives a one-cycle completion strobe. An error flag comes with that strobe when the routine was the exception routine.

Software fills the pattern RAM through a write port while the engine is idle. Loading correct routines is the user's responsibility, and a request that arrives before loading still runs.

Top module: `pseq_engine`

## Requirements
- R1: While idle, a memory request starts at word 0x00 for a single-beat read, 0x08 for a burst read, 0x18 for a single-beat write and 0x20 for a burst write (`mem_wr` 1 means write, `mem_burst` 1 means burst). `cur_addr` shows that word in the first busy cycle.
- R2: While idle, `refresh_req` starts the routine at word 0x30.
- R3: While idle, `cmd_valid` with `cmd_op` equal to 2'b11 starts the routine at `cmd_index`. Any other `cmd_op` value starts nothing.
- R4: When several requests are present in the same idle cycle, the timeout wins over refresh, refresh wins over RUN, and RUN wins over a memory request.
- R5: A pattern word is {last bit [CTRL_W+1], ack-sample bit [CTRL_W], control field [CTRL_W-1:0]}. A word whose ack-sample bit is clear is shown for exactly one cycle and ignores `xfer_ack`. The routine ends after a word whose last bit is set. While busy, `ctrl_out` is the current word's control field.
- R6: An ack-sample word of a single-beat access, or of a refresh, RUN or exception routine, holds until one `xfer_ack` has been sampled while it is current.
- R7: An ack-sample word of a burst holds until 32 acknowledges have been sampled for `port_size` 2'b00 (8-bit), 16 for 2'b01 (16-bit), and 8 for 2'b10 or 2'b11 (32-bit).
- R8: `bmon_timeout` while idle, or while busy in any routine other than the exception routine, moves execution to word 0x3C on the next cycle. A timeout during the exception routine has no effect.
- R9: `done` is high for exactly one cycle, in the cycle after the last word was shown. `err` is high together with `done` only when the routine that ended was the exception routine.
- R10: While busy, refresh, RUN and memory requests are dropped and are not kept for later.
- R11: A RAM load is written only while idle. A load presented while busy leaves the RAM unchanged.
- R12: After reset the engine is idle with `done`, `err`, `ctrl_out` and `cur_addr` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | input | 1 | Memory access request |
| mem_wr | input | 1 | 1 = write, 0 = read |
| mem_burst | input | 1 | 1 = burst, 0 = single beat |
| port_size | input | 2 | 00 8-bit, 01 16-bit, 10/11 32-bit; sampled at routine start |
| refresh_req | input | 1 | Refresh tick request |
| cmd_valid | input | 1 | Software command strobe |
| cmd_op | input | 2 | Command opcode; 2'b11 = RUN |
| cmd_index | input | ADDR_W | RUN start word |
| bmon_timeout | input | 1 | Bus-monitor timeout |
| xfer_ack | input | 1 | Transfer acknowledge |
| load_en | input | 1 | Pattern RAM write strobe |
| load_addr | input | ADDR_W | Pattern RAM write index |
| load_data | input | CTRL_W+2 | Pattern word {last, ack-sample, control} |
| busy | output | 1 | A routine is executing |
| cur_addr | output | ADDR_W | Index of the current pattern word |
| ctrl_out | output | CTRL_W | Control field of the current word; zero when idle |
| done | output | 1 | One-cycle routine completion strobe |
| err | output | 1 | With `done`: the ended routine was the exception routine |

## Verification
The assertions assume that every word a routine reaches has been loaded, so that its last and ack-sample bits are defined. They also assume that `bmon_timeout` is the only request input the engine acts on while busy. The bench writes every routine word before the first request. It lowers each timeout before the exception routine ends, so the timeout cannot be read as a fresh launch in the idle completion cycle. It holds `xfer_ack` high through non-sampling words to show that it is ignored there.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;
   // fixed routine entry points
   localparam logic [5:0] ENTRY_RD_ONE  = 6'h00;
   localparam logic [5:0] ENTRY_RD_BST  = 6'h08;
   localparam logic [5:0] ENTRY_WR_ONE  = 6'h18;
   localparam logic [5:0] ENTRY_WR_BST  = 6'h20;
   localparam logic [5:0] ENTRY_REFRESH = 6'h30;
   localparam logic [5:0] ENTRY_EXCEPT  = 6'h3C;

   localparam logic [1:0] OPC_RUN = 2'b11;

   typedef enum logic [1:0] {
      PW_BYTE  = 2'b00,
      PW_HALF  = 2'b01,
      PW_WORD  = 2'b10,
      PW_WORDX = 2'b11
   } port_w_e;
endpackage

// File: rtl/pseq_ram.sv
`timescale 1ns/1ps
module pseq_ram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // combinational read: one pattern word per clock with no bubble
   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pseq_launch_sel.sv
`timescale 1ns/1ps
module pseq_launch_sel
   import pseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned BEAT_W      = 6,
   parameter int unsigned BURST_BYTES = 32
) (
   input  logic              timeout,
   input  logic              rfsh_req,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_index,
   input  logic              mem_req,
   input  logic              mem_wr,
   input  logic              mem_burst,
   input  logic [1:0]        port_w,
   output logic              launch,
   output logic              launch_exc,
   output logic [ADDR_W-1:0] start_addr,
   output logic [BEAT_W-1:0] beat_init
);
   function automatic logic [BEAT_W-1:0] burst_len(input logic [1:0] pw);
      case (port_w_e'(pw))
         PW_BYTE: burst_len = BEAT_W'(BURST_BYTES);
         PW_HALF: burst_len = BEAT_W'(BURST_BYTES / 2);
         default: burst_len = BEAT_W'(BURST_BYTES / 4);
      endcase
   endfunction

   always_comb begin
      launch     = 1'b1;
      launch_exc = 1'b0;
      start_addr = '0;
      beat_init  = BEAT_W'(1);
      if (timeout) begin
         launch_exc = 1'b1;
         start_addr = ADDR_W'(ENTRY_EXCEPT);
      end else if (rfsh_req) begin
         start_addr = ADDR_W'(ENTRY_REFRESH);
      end else if (cmd_valid && cmd_op == OPC_RUN) begin
         start_addr = cmd_index;
      end else if (mem_req) begin
         case ({mem_wr, mem_burst})
            2'b00:   start_addr = ADDR_W'(ENTRY_RD_ONE);
            2'b01:   start_addr = ADDR_W'(ENTRY_RD_BST);
            2'b10:   start_addr = ADDR_W'(ENTRY_WR_ONE);
            default: start_addr = ADDR_W'(ENTRY_WR_BST);
         endcase
         if (mem_burst) beat_init = burst_len(port_w);
      end else begin
         launch = 1'b0;
      end
   end
endmodule

// File: rtl/pseq_beat_ctr.sv
`timescale 1ns/1ps
module pseq_beat_ctr #(
   parameter int unsigned BEAT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              load,
   input  logic [BEAT_W-1:0] load_val,
   input  logic              ack_hit,
   output logic              final_beat
);
   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] init_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= BEAT_W'(1);
         init_q <= BEAT_W'(1);
      end else if (load) begin
         cnt_q  <= load_val;
         init_q <= load_val;
      end else if (ack_hit) begin
         // rewind on the closing beat so a later sampling word gets a full count
         cnt_q <= (cnt_q == BEAT_W'(1)) ? init_q : cnt_q - BEAT_W'(1);
      end
   end

   assign final_beat = (cnt_q == BEAT_W'(1));

   // R7
   beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q != '0 && cnt_q <= init_q));
endmodule

// File: rtl/pseq_engine.sv
`timescale 1ns/1ps
module pseq_engine
   import pseq_pkg::*;
#(
   parameter int unsigned CTRL_W      = 8,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned BURST_BYTES = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mem_req,
   input  logic                mem_wr,
   input  logic                mem_burst,
   input  logic [1:0]          port_size,
   input  logic                refresh_req,
   input  logic                cmd_valid,
   input  logic [1:0]          cmd_op,
   input  logic [ADDR_W-1:0]   cmd_index,
   input  logic                bmon_timeout,
   input  logic                xfer_ack,
   input  logic                load_en,
   input  logic [ADDR_W-1:0]   load_addr,
   input  logic [CTRL_W+1:0]   load_data,
   output logic                busy,
   output logic [ADDR_W-1:0]   cur_addr,
   output logic [CTRL_W-1:0]   ctrl_out,
   output logic                done,
   output logic                err
);
   localparam int unsigned WORD_W   = CTRL_W + 2;
   localparam int unsigned BIT_LAST = WORD_W - 1;
   localparam int unsigned BIT_ACK  = WORD_W - 2;
   localparam int unsigned BEAT_W   = $clog2(BURST_BYTES + 1);

   initial begin
      assert (ADDR_W >= 6) else $error("pattern RAM needs at least 64 words");
      assert (CTRL_W >= 1) else $error("control field must be non-empty");
      assert (BURST_BYTES >= 4 && BURST_BYTES % 4 == 0)
         else $error("burst size must be a multiple of four bytes");
   end

   logic                busy_q, in_exc_q, done_q, err_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [WORD_W-1:0]   word;
   logic                w_last, w_ack;
   logic                launch, launch_exc;
   logic [ADDR_W-1:0]   start_addr;
   logic [BEAT_W-1:0]   beat_init;
   logic                final_beat;
   logic                preempt, ack_hit, step, finish;

   pseq_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
      .clk     (clk),
      .wr_en   (load_en && !busy_q),
      .wr_addr (load_addr),
      .wr_data (load_data),
      .rd_addr (pc_q),
      .rd_data (word)
   );

   pseq_launch_sel #(
      .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BURST_BYTES(BURST_BYTES)
   ) u_sel (
      .timeout    (bmon_timeout),
      .rfsh_req   (refresh_req),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_index  (cmd_index),
      .mem_req    (mem_req),
      .mem_wr     (mem_wr),
      .mem_burst  (mem_burst),
      .port_w     (port_size),
      .launch     (launch),
      .launch_exc (launch_exc),
      .start_addr (start_addr),
      .beat_init  (beat_init)
   );

   assign w_last  = word[BIT_LAST];
   assign w_ack   = word[BIT_ACK];
   assign preempt = busy_q && bmon_timeout && !in_exc_q;
   assign ack_hit = busy_q && !preempt && w_ack && xfer_ack;
   assign step    = busy_q && !preempt && (!w_ack || (xfer_ack && final_beat));
   assign finish  = step && w_last;

   pseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beats (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy_q),
      .load       ((!busy_q && launch) || preempt),
      .load_val   (preempt ? BEAT_W'(1) : beat_init),
      .ack_hit    (ack_hit),
      .final_beat (final_beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         in_exc_q <= 1'b0;
         pc_q     <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= finish;
         err_q  <= finish && in_exc_q;
         if (!busy_q) begin
            if (launch) begin
               busy_q   <= 1'b1;
               pc_q     <= start_addr;
               in_exc_q <= launch_exc;
            end
         end else if (preempt) begin
            pc_q     <= ADDR_W'(ENTRY_EXCEPT);
            in_exc_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
         end else if (step) begin
            pc_q <= pc_q + ADDR_W'(1);
         end
      end
   end

   assign busy     = busy_q;
   assign cur_addr = pc_q;
   assign ctrl_out = busy_q ? word[CTRL_W-1:0] : '0;
   assign done     = done_q;
   assign err      = err_q;

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !busy));
   // R8
   timeout_divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bmon_timeout && !in_exc_q) |=> (busy_q && pc_q == ADDR_W'(ENTRY_EXCEPT)));
   // R6
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && w_ack && !xfer_ack && !bmon_timeout) |=> (busy_q && $stable(pc_q)));
   // R5
   plain_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !w_ack && !w_last && !bmon_timeout) |=> (busy_q && pc_q == $past(pc_q) + ADDR_W'(1)));
   // R10
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bmon_timeout && !w_last) |=> busy_q);
endmodule

// File: tb/test_pseq_engine.sv
`timescale 1ns/1ps
module test_pseq_engine;
   localparam int CW = 8;
   localparam int AW = 6;
   localparam int WW = CW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_req = 0, mem_wr = 0, mem_burst = 0;
   logic [1:0]    port_size = 2'b10;
   logic          refresh_req = 0, cmd_valid = 0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_index = '0;
   logic          bmon_timeout = 0, xfer_ack = 0, load_en = 0;
   logic [AW-1:0] load_addr = '0;
   logic [WW-1:0] load_data = '0;
   logic          busy, done, err;
   logic [AW-1:0] cur_addr;
   logic [CW-1:0] ctrl_out;

   pseq_engine #(.CTRL_W(CW), .ADDR_W(AW), .BURST_BYTES(32)) i_pseq_engine (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_wr(mem_wr),
      .mem_burst(mem_burst), .port_size(port_size), .refresh_req(refresh_req),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
      .bmon_timeout(bmon_timeout), .xfer_ack(xfer_ack), .load_en(load_en),
      .load_addr(load_addr), .load_data(load_data), .busy(busy),
      .cur_addr(cur_addr), .ctrl_out(ctrl_out), .done(done), .err(err)
   );

   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   logic [WW-1:0] img [64];

   typedef struct packed {
      logic          is_done;
      logic [AW-1:0] addr;
      logic [CW-1:0] ctrl;
      logic          err;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  cur_e;
   string cur_t;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic push_word(input logic [AW-1:0] a, input int n, input string t);
      exp_t e;
      for (int i = 0; i < n; i++) begin
         e = {1'b0, a, img[a][CW-1:0], 1'b0};
         exp_q.push_back(e);
         tag_q.push_back(t);
      end
   endtask

   task automatic push_done(input logic e_err, input string t);
      exp_t e;
      e = {1'b1, {AW{1'b0}}, {CW{1'b0}}, e_err};
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   // walk a routine as the requirements describe it
   task automatic push_routine(input logic [AW-1:0] s, input int beats, input int stall, input string t);
      logic [AW-1:0] a;
      a = s;
      for (int k = 0; k < 64; k++) begin
         push_word(a, img[a][CW] ? stall + beats : 1, t);
         if (img[a][CW+1]) break;
         a = a + 1'b1;
      end
   endtask

   function automatic int beats_for(input logic bst, input logic [1:0] ps);
      if (!bst) return 1;
      case (ps)
         2'b00:   return 32;
         2'b01:   return 16;
         default: return 8;
      endcase
   endfunction

   function automatic logic [AW-1:0] entry_for(input logic wr, input logic bst);
      case ({wr, bst})
         2'b00:   return 6'h00;
         2'b01:   return 6'h08;
         2'b10:   return 6'h18;
         default: return 6'h20;
      endcase
   endfunction

   task automatic load_word(input logic [AW-1:0] a, input logic last, input logic ack, input logic [CW-1:0] c);
      @(negedge clk);
      load_en = 1'b1; load_addr = a; load_data = {last, ack, c};
      img[a] = {last, ack, c};
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic fire(input logic t_exc, input logic t_rf, input logic t_run, input logic [1:0] op,
                       input logic [AW-1:0] idx, input logic t_mem, input logic wr, input logic bst,
                       input logic [1:0] ps, input int stall);
      @(negedge clk);
      bmon_timeout = t_exc; refresh_req = t_rf; cmd_valid = t_run; cmd_op = op; cmd_index = idx;
      mem_req = t_mem; mem_wr = wr; mem_burst = bst; port_size = ps; xfer_ack = (stall == 0);
      @(negedge clk);
      bmon_timeout = 0; refresh_req = 0; cmd_valid = 0; mem_req = 0;
      repeat (stall) @(negedge clk);
      xfer_ack = 1'b1;
   endtask

   task automatic wait_done;
      while (!done) @(negedge clk);
      xfer_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic mem_case(input logic wr, input logic bst, input logic [1:0] ps, input int stall, input string t);
      push_routine(entry_for(wr, bst), beats_for(bst, ps), stall, t);
      push_done(1'b0, t);
      fire(0, 0, 0, 2'b00, '0, 1, wr, bst, ps, stall);
      wait_done();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on && (busy || done)) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10 unexpected activity: busy=%0b addr=%0h done=%0b, expected idle",
                     busy, cur_addr, done);
         end else begin
            cur_e = exp_q.pop_front();
            cur_t = tag_q.pop_front();
            if (cur_e.is_done) begin
               if (!(done && !busy && err == cur_e.err)) begin
                  n_bad++;
                  $display("FAIL %s completion: done=%0b busy=%0b err=%0b, expected done=1 err=%0b",
                           cur_t, done, busy, err, cur_e.err);
               end
            end else if (!(busy && !done && cur_addr == cur_e.addr && ctrl_out == cur_e.ctrl)) begin
               n_bad++;
               $display("FAIL %s word: busy=%0b addr=%0h ctrl=%0h, expected addr=%0h ctrl=%0h",
                        cur_t, busy, cur_addr, ctrl_out, cur_e.addr, cur_e.ctrl);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R5 watchdog: busy=%0b, expected run to finish", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check(busy == 0, "R12 busy", busy, 0);
      check(done == 0 && err == 0, "R12 done/err", {done, err}, 0);
      check(ctrl_out == 0 && cur_addr == 0, "R12 outputs", {ctrl_out, cur_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      load_word(6'h00, 0, 1, 8'h11); load_word(6'h01, 1, 0, 8'h12);
      load_word(6'h08, 0, 1, 8'h21); load_word(6'h09, 1, 0, 8'h22);
      load_word(6'h18, 0, 1, 8'h31); load_word(6'h19, 1, 0, 8'h32);
      load_word(6'h20, 0, 1, 8'h41); load_word(6'h21, 0, 0, 8'h42); load_word(6'h22, 1, 0, 8'h43);
      load_word(6'h28, 0, 0, 8'h51); load_word(6'h29, 1, 0, 8'h52);
      load_word(6'h30, 0, 0, 8'h61); load_word(6'h31, 0, 0, 8'h62); load_word(6'h32, 1, 0, 8'h63);
      load_word(6'h3C, 0, 0, 8'h71); load_word(6'h3D, 1, 0, 8'h72);

      // R1 R6 single-beat accesses, with and without acknowledge stalls
      mem_case(0, 0, 2'b10, 0, "R1 R6 read single");
      mem_case(0, 0, 2'b10, 3, "R6 read single stalled");
      mem_case(1, 0, 2'b00, 0, "R1 write single");
      // R7 burst beat counts per port width
      mem_case(0, 1, 2'b00, 0, "R7 read burst 8-bit");
      mem_case(0, 1, 2'b01, 0, "R7 read burst 16-bit");
      mem_case(1, 1, 2'b10, 0, "R1 R7 write burst 32-bit");
      mem_case(1, 1, 2'b11, 2, "R7 write burst code 11 stalled");

      // R2 R5 refresh, ack held high through plain words
      push_routine(6'h30, 1, 0, "R2 R5 refresh");
      push_done(1'b0, "R2");
      fire(0, 1, 0, 2'b00, '0, 0, 0, 0, 2'b10, 0);
      wait_done();

      // R3 RUN at an arbitrary word
      push_routine(6'h28, 1, 0, "R3 run");
      push_done(1'b0, "R3");
      fire(0, 0, 1, 2'b11, 6'h28, 0, 0, 0, 2'b10, 0);
      wait_done();

      // R3 non-RUN opcode starts nothing
      fire(0, 0, 1, 2'b01, 6'h28, 0, 0, 0, 2'b10, 0);
      xfer_ack = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 0, "R3 non-run opcode", busy, 0);

      // R4 R8 R9 all requests at once: timeout wins, err with done
      push_routine(6'h3C, 1, 0, "R4 R8 exception first");
      push_done(1'b1, "R9 err");
      fire(1, 1, 1, 2'b11, 6'h28, 1, 0, 0, 2'b10, 0);
      wait_done();

      // R4 refresh over RUN and memory
      push_routine(6'h30, 1, 0, "R4 refresh over run");
      push_done(1'b0, "R4");
      fire(0, 1, 1, 2'b11, 6'h28, 1, 0, 0, 2'b10, 0);
      wait_done();

      // R4 RUN over memory
      push_routine(6'h28, 1, 0, "R4 run over mem");
      push_done(1'b0, "R4");
      fire(0, 0, 1, 2'b11, 6'h28, 1, 1, 1, 2'b10, 0);
      wait_done();

      // R8 timeout preempts a running burst after five cycles
      push_word(6'h20, 5, "R8 preempted burst");
      push_routine(6'h3C, 1, 0, "R8 exception");
      push_done(1'b1, "R8 R9");
      @(negedge clk);
      mem_req = 1; mem_wr = 1; mem_burst = 1; port_size = 2'b00; xfer_ack = 1;
      @(negedge clk);
      mem_req = 0;
      repeat (4) @(negedge clk);
      bmon_timeout = 1;
      @(negedge clk);
      bmon_timeout = 0;
      wait_done();

      // R8 timeout inside the exception routine is ignored
      push_routine(6'h3C, 1, 0, "R8 nested timeout");
      push_done(1'b1, "R8 R9");
      @(negedge clk);
      bmon_timeout = 1;
      @(negedge clk);
      @(negedge clk);
      bmon_timeout = 0;
      wait_done();

      // R10 R11 requests and a load while busy are dropped
      push_routine(6'h30, 1, 0, "R10 refresh");
      push_done(1'b0, "R10");
      @(negedge clk);
      refresh_req = 1;
      @(negedge clk);
      refresh_req = 0; mem_req = 1; mem_wr = 0; mem_burst = 0;
      cmd_valid = 1; cmd_op = 2'b11; cmd_index = 6'h00;
      @(negedge clk);
      mem_req = 0; cmd_valid = 0;
      load_en = 1; load_addr = 6'h28; load_data = {2'b10, 8'hEE};
      @(negedge clk);
      load_en = 0;
      wait_done();
      repeat (3) @(negedge clk);
      check(busy == 0, "R10 nothing queued", busy, 0);
      push_routine(6'h28, 1, 0, "R11 ram kept");
      push_done(1'b0, "R11");
      fire(0, 0, 1, 2'b11, 6'h28, 0, 0, 0, 2'b10, 0);
      wait_done();

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule